// File: doc/BRIEF.md
# Hashed Page Table Lookup Engine

This block translates a 32-bit effective address by walking a hashed page table held in a word-addressed memory. Segments map one-to-one from effective to virtual space. A request carries the address, the table's base and the table's size. The engine computes a primary hash and scans the eight entries of that group. If none of them matches, it complements the hash and scans the eight entries of a second group. It then reports hit or miss, together with the real page number, the cache attributes and the protection bits of the winning entry.

Requests use a valid/ready handshake. `req_ready` is high only while the engine is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, a `req_valid` is not queued and has no effect, so a caller must hold its request until the engine is ready again. Results carry no back-pressure. They appear with a single-cycle `done` pulse and stay on the result pins until the next lookup completes. Table memory sits behind a plain synchronous read port that takes one 32-bit word per cycle and returns data one cycle later.

Top module: `hpt_walker`

## Requirements
- R1: The address splits as follows: segment id = ea[31:28], page index = ea[27:12], and the page offset is ignored. The expected virtual segment id is the segment id zero-extended to 24 bits. The expected abbreviated index is page index >> 10 (6 bits).
- R2: The primary hash is (segment id XOR page index) in 19 bits. A group's byte address is base OR ((hash << 6) AND (size − 1)). Entry n of a group lies at byte offset 8·n: its first word is at +0 and its second word at +4.
- R3: The secondary hash is the bitwise NOT of the primary hash in 19 bits. It forms a group address by the same rule as the primary hash.
- R4: First-word layout: bit 31 = valid, bits 30:7 = virtual segment id, bit 6 = hash select, bits 5:0 = abbreviated index. An entry matches only when it is valid, both ids are equal, and hash select is 0 in the primary group or 1 in the secondary group.
- R5: The engine reads entries 0..7 of the primary group before any entry of the secondary group. The first matching entry in that order wins.
- R6: A miss (`res_hit` = 0) is reported only after all 16 entries have been read and none matches. On a miss, `res_rpn`, `res_wimg` and `res_pp` are zero.
- R7: Second-word layout: bits 31:12 = real page number, bits 6:3 = cache attributes, bits 1:0 = protection. On a hit these three fields are returned. Bits 11:7 and bit 2 (pad, referenced, changed, software mark) have no effect.
- R8: `req_ready` is high exactly when the engine is idle. A `req_valid` that arrives while busy is ignored: it does not change the result of the lookup in progress and does not start a new lookup.
- R9: `done` is high for exactly one cycle per accepted request. The result pins are valid in that cycle.
- R10: `mem_rd_en` is high for one word per cycle and every address read lies inside the table. A lookup reads exactly one first word for each entry it examines, plus one second word when it hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_ea | input | 32 | Effective address to translate |
| req_base | input | 32 | Table byte base, aligned to its size |
| req_size | input | 32 | Table byte size, power of two, at least 64 KiB |
| mem_rd_en | output | 1 | Table memory read strobe |
| mem_addr | output | 30 | Table memory word address |
| mem_rdata | input | 32 | Read data, valid one cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| res_hit | output | 1 | A matching entry was found |
| res_rpn | output | 20 | Real page number of the match |
| res_wimg | output | 4 | Cache attributes of the match |
| res_pp | output | 2 | Protection bits of the match |

## Verification
The bench fills the primary groups with decoys and then places the real entry in specific slots. The decoys are invalid entries whose ids do match, entries with the wrong hash-select bit, entries with a wrong abbreviated index, and entries with a wrong segment id. A design that ignored the hash-select bit or the valid bit would return a decoy. One whose secondary group was not the complement would read the wrong addresses and miss. The bench also places matching entries in both groups, and two matching entries in one group. A design that scanned out of order or let a later entry override an earlier one would return the wrong page number and read a different number of words. Miss cases check that all 16 entries are read and that the fields come back zeroed. A request driven during a busy lookup must leave the result alone and must not produce a second done pulse.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_TAG,
    ST_CK_TAG,
    ST_RD_DATA,
    ST_CK_DATA
  } hpt_state_e;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int PI_W   = 16,
  parameter int HASH_W = 19,
  parameter int GRP_LD = 6
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [PI_W-1:0]   pi_i,
  input  logic              sec_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic [ADDR_W-1:0] grp_o
);
  logic [HASH_W-1:0] h_pri;
  logic [HASH_W-1:0] h_sel;

  always_comb begin
    h_pri = HASH_W'(seg_i) ^ HASH_W'(pi_i);
    h_sel = sec_i ? ~h_pri : h_pri;
    grp_o = base_i | ((ADDR_W'(h_sel) << GRP_LD) & mask_i);
  end
endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
  parameter int SEG_W  = 4,
  parameter int VSID_W = 24,
  parameter int API_W  = 6
) (
  input  logic [VSID_W+API_W+1:0] tag_i,
  input  logic [SEG_W-1:0]        seg_i,
  input  logic [API_W-1:0]        api_i,
  input  logic                    sec_i,
  output logic                    hit_o
);
  localparam int TAG_W = VSID_W + API_W + 2;

  logic              t_valid;
  logic [VSID_W-1:0] t_vsid;
  logic              t_hsel;
  logic [API_W-1:0]  t_api;

  always_comb begin
    t_valid = tag_i[TAG_W-1];
    t_vsid  = tag_i[TAG_W-2 -: VSID_W];
    t_hsel  = tag_i[API_W];
    t_api   = tag_i[API_W-1:0];
    hit_o   = t_valid && (t_vsid == VSID_W'(seg_i)) &&
              (t_hsel == sec_i) && (t_api == api_i);
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SEG_W     = 4,
  parameter int PG_W      = 12,
  parameter int HASH_W    = 19,
  parameter int VSID_W    = 24,
  parameter int RPN_W     = 20,
  parameter int GRP_LD    = 6,
  parameter int ENT_LD    = 3,
  parameter int MIN_PT_LD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_ea,
  input  logic [31:0]       req_base,
  input  logic [31:0]       req_size,
  output logic              mem_rd_en,
  output logic [29:0]       mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic              res_hit,
  output logic [RPN_W-1:0]  res_rpn,
  output logic [3:0]        res_wimg,
  output logic [1:0]        res_pp
);
  localparam int PI_W    = ADDR_W - SEG_W - PG_W;
  localparam int API_W   = PI_W - (MIN_PT_LD - GRP_LD);
  localparam int ENTRIES = 1 << (GRP_LD - ENT_LD);
  localparam int IDX_W   = GRP_LD - ENT_LD;
  localparam int TAG_W   = VSID_W + API_W + 2;
  localparam int WIMG_LSB = 3;
  localparam int WORD_LD = 2;

  hpt_state_e        state_q;
  logic [ADDR_W-1:0] ea_q, base_q, mask_q;
  logic              pass_q;
  logic [IDX_W-1:0]  idx_q;
  logic              done_q, hit_q;
  logic [RPN_W-1:0]  rpn_q;
  logic [3:0]        wimg_q;
  logic [1:0]        pp_q;

  logic [SEG_W-1:0]  seg;
  logic [PI_W-1:0]   pidx;
  logic [API_W-1:0]  api;
  logic [ADDR_W-1:0] grp_base, ent_byte;
  logic              word_sel, tag_hit;

  assign seg  = ea_q[ADDR_W-1 -: SEG_W];
  assign pidx = ea_q[PG_W +: PI_W];
  assign api  = pidx[PI_W-1 -: API_W];

  hpt_hash #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .PI_W(PI_W),
    .HASH_W(HASH_W), .GRP_LD(GRP_LD)
  ) u_hash (
    .seg_i(seg), .pi_i(pidx), .sec_i(pass_q),
    .base_i(base_q), .mask_i(mask_q), .grp_o(grp_base)
  );

  hpt_match #(
    .SEG_W(SEG_W), .VSID_W(VSID_W), .API_W(API_W)
  ) u_match (
    .tag_i(mem_rdata[TAG_W-1:0]), .seg_i(seg), .api_i(api),
    .sec_i(pass_q), .hit_o(tag_hit)
  );

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    mem_rd_en = (state_q == ST_RD_TAG) || (state_q == ST_RD_DATA);
    word_sel  = (state_q == ST_RD_DATA);
    ent_byte  = grp_base | ADDR_W'({idx_q, word_sel, {WORD_LD{1'b0}}});
    mem_addr  = ent_byte[ADDR_W-1:WORD_LD];
    done      = done_q;
    res_hit   = hit_q;
    res_rpn   = rpn_q;
    res_wimg  = wimg_q;
    res_pp    = pp_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      pass_q  <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      rpn_q   <= '0;
      wimg_q  <= '0;
      pp_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            ea_q    <= req_ea;
            base_q  <= req_base;
            mask_q  <= req_size - 32'd1;
            pass_q  <= 1'b0;
            idx_q   <= '0;
            state_q <= ST_RD_TAG;
          end
        end
        ST_RD_TAG:  state_q <= ST_CK_TAG;
        ST_CK_TAG: begin
          if (tag_hit) begin
            state_q <= ST_RD_DATA;
          end else if (idx_q == IDX_W'(ENTRIES-1)) begin
            idx_q <= '0;
            if (!pass_q) begin
              pass_q  <= 1'b1;
              state_q <= ST_RD_TAG;
            end else begin
              done_q  <= 1'b1;
              hit_q   <= 1'b0;
              rpn_q   <= '0;
              wimg_q  <= '0;
              pp_q    <= '0;
              state_q <= ST_IDLE;
            end
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_RD_TAG;
          end
        end
        ST_RD_DATA: state_q <= ST_CK_DATA;
        ST_CK_DATA: begin
          done_q  <= 1'b1;
          hit_q   <= 1'b1;
          rpn_q   <= mem_rdata[31 -: RPN_W];
          wimg_q  <= mem_rdata[WIMG_LSB +: 4];
          pp_q    <= mem_rdata[1:0];
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_rd_in_table_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (({mem_addr, 2'b00} & ~mask_q) == base_q));

  assert_secondary_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_q) |-> $past(idx_q) == IDX_W'(ENTRIES-1));

  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !res_hit |-> (res_rpn == '0) && (res_wimg == '0) && (res_pp == '0));
endmodule

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_ea, req_base, req_size;
  logic        mem_rd_en;
  logic [29:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        done, res_hit;
  logic [19:0] res_rpn;
  logic [3:0]  res_wimg;
  logic [1:0]  res_pp;

  hpt_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_base(req_base), .req_size(req_size),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .res_hit(res_hit), .res_rpn(res_rpn),
    .res_wimg(res_wimg), .res_pp(res_pp)
  );

  int errors = 0;
  int checks = 0;
  int rd_total = 0;
  logic [31:0] tbl [int unsigned];

  function automatic logic [31:0] rd_word(logic [29:0] a);
    int unsigned k = {2'b00, a};
    if (tbl.exists(k)) return tbl[k];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      rd_total  <= rd_total + 1;
      mem_rdata <= rd_word(mem_addr);
    end else begin
      mem_rdata <= 32'hDEAD_BEEF;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] grp_of(logic [31:0] base, logic [31:0] size,
                                         logic [31:0] ea, bit sec);
    logic [18:0] h;
    h = {15'b0, ea[31:28]} ^ {3'b0, ea[27:12]};
    if (sec) h = ~h;
    return base | ({7'b0, h, 6'b0} & (size - 32'd1));
  endfunction

  function automatic int unsigned slot_word(logic [31:0] base, logic [31:0] size,
                                            logic [31:0] ea, bit sec, int slot, int w);
    logic [31:0] b;
    b = grp_of(base, size, ea, sec) + 32'(slot * 8 + w * 4);
    return {2'b00, b[31:2]};
  endfunction

  function automatic logic [31:0] mk_tag(bit v, logic [23:0] vsid, bit h, logic [5:0] api);
    return {v, vsid, h, api};
  endfunction

  function automatic logic [31:0] mk_data(logic [19:0] rpn, logic [3:0] wimg,
                                          logic [1:0] pp, logic [4:0] junk);
    return {rpn, junk[4:2], junk[1], junk[0], wimg, 1'b1, pp};
  endfunction

  task automatic put_entry(logic [31:0] base, logic [31:0] size, logic [31:0] ea,
                           bit sec, int slot, logic [19:0] rpn, logic [3:0] wimg,
                           logic [1:0] pp);
    tbl[slot_word(base, size, ea, sec, slot, 0)] =
      mk_tag(1'b1, {20'b0, ea[31:28]}, sec, ea[27:22]);
    tbl[slot_word(base, size, ea, sec, slot, 1)] = mk_data(rpn, wimg, pp, 5'($urandom));
  endtask

  task automatic fill_decoys(logic [31:0] base, logic [31:0] size, logic [31:0] ea, bit sec);
    for (int s = 0; s < 8; s++) begin
      logic [23:0] vs;
      logic [5:0]  ap;
      logic [31:0] t;
      vs = {20'b0, ea[31:28]};
      ap = ea[27:22];
      case (s % 5)
        0: t = 32'h0;
        1: t = mk_tag(1'b0, vs, sec, ap);
        2: t = mk_tag(1'b1, vs, ~sec, ap);
        3: t = mk_tag(1'b1, vs, sec, ap ^ 6'(1 + $urandom % 63));
        default: t = mk_tag(1'b1, vs ^ 24'(1 + $urandom % 255), sec, ap);
      endcase
      tbl[slot_word(base, size, ea, sec, s, 0)] = t;
      tbl[slot_word(base, size, ea, sec, s, 1)] = mk_data(20'hBAD00, 4'hF, 2'h3, 5'h1F);
    end
  endtask

  task automatic ref_lookup(input logic [31:0] ea, base, size,
                            output bit hit, output logic [19:0] rpn,
                            output logic [3:0] wimg, output logic [1:0] pp,
                            output int reads);
    hit = 0; rpn = '0; wimg = '0; pp = '0; reads = 0;
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 8; s++) begin
        logic [31:0] t, d;
        t = rd_word(30'(slot_word(base, size, ea, p[0], s, 0)));
        reads++;
        if (t[31] && t[30:7] == {20'b0, ea[31:28]} && t[6] == p[0] && t[5:0] == ea[27:22]) begin
          d = rd_word(30'(slot_word(base, size, ea, p[0], s, 1)));
          reads++;
          hit = 1; rpn = d[31:12]; wimg = d[6:3]; pp = d[1:0];
          return;
        end
      end
    end
  endtask

  bit          g_hit;
  logic [19:0] g_rpn;
  logic [3:0]  g_wimg;
  logic [1:0]  g_pp;
  int          g_reads;

  task automatic run(input logic [31:0] ea, base, size, input bit poke);
    int start;
    int n;
    int dones;
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_base = base; req_size = size;
    start = rd_total;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      chk("R8", "ready low while busy", {31'b0, req_ready}, 32'd0);
      req_valid = 1'b1;
      req_ea = ea ^ 32'h1000_0000;
      req_base = base ^ size;
    end
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk("R9", "done seen", {31'b0, done}, 32'd1);
    g_hit = res_hit; g_rpn = res_rpn; g_wimg = res_wimg; g_pp = res_pp;
    g_reads = rd_total - start;
    dones = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R9", "no extra done pulse", 32'(dones), 32'd0);
  endtask

  task automatic expect_res(string req, bit hit, logic [19:0] rpn, logic [3:0] wimg,
                            logic [1:0] pp, int reads);
    chk(req, "hit", {31'b0, g_hit}, {31'b0, hit});
    chk(req, "rpn", {12'b0, g_rpn}, {12'b0, rpn});
    chk(req, "wimg", {28'b0, g_wimg}, {28'b0, wimg});
    chk(req, "pp", {30'b0, g_pp}, {30'b0, pp});
    chk("R10", "word reads", 32'(g_reads), 32'(reads));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] ea, base, size;
    bit          e_hit;
    logic [19:0] e_rpn;
    logic [3:0]  e_wimg;
    logic [1:0]  e_pp;
    int          e_reads;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; req_valid = 1'b0; req_ea = '0; req_base = '0; req_size = 32'h10000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", "reset ready", {31'b0, req_ready}, 32'd1);
    chk("R9", "reset done", {31'b0, done}, 32'd0);
    chk("R10", "reset rd_en", {31'b0, mem_rd_en}, 32'd0);
    rst_n = 1'b1;

    // R1 R2 R4: primary slot 0, fields decoded from a known address
    base = 32'h0040_0000; size = 32'h0001_0000; ea = 32'h3ABC_D123;
    tbl.delete();
    fill_decoys(base, size, ea, 1'b0);
    put_entry(base, size, ea, 1'b0, 0, 20'h12345, 4'h6, 2'h2);
    run(ea, base, size, 1'b0);
    expect_res("R1", 1'b1, 20'h12345, 4'h6, 2'h2, 2);

    // R3 R4 R7: primary full of decoys, hit in secondary slot 3
    tbl.delete();
    fill_decoys(base, size, ea, 1'b0);
    fill_decoys(base, size, ea, 1'b1);
    put_entry(base, size, ea, 1'b1, 3, 20'hABCDE, 4'h9, 2'h1);
    run(ea, base, size, 1'b0);
    expect_res("R3", 1'b1, 20'hABCDE, 4'h9, 2'h1, 13);

    // R4: an entry with H=1 sitting in the primary group must not match
    tbl.delete();
    tbl[slot_word(base, size, ea, 1'b0, 0, 0)] = mk_tag(1'b1, {20'b0, ea[31:28]}, 1'b1, ea[27:22]);
    tbl[slot_word(base, size, ea, 1'b0, 0, 1)] = mk_data(20'h0F0F0, 4'h1, 2'h1, 5'h0);
    run(ea, base, size, 1'b0);
    expect_res("R4", 1'b0, 20'h0, 4'h0, 2'h0, 16);

    // R5: two matches in primary group, slot 2 wins over slot 5
    tbl.delete();
    put_entry(base, size, ea, 1'b0, 5, 20'h55555, 4'h5, 2'h3);
    put_entry(base, size, ea, 1'b0, 2, 20'h22222, 4'h2, 2'h0);
    run(ea, base, size, 1'b0);
    expect_res("R5", 1'b1, 20'h22222, 4'h2, 2'h0, 4);

    // R5: primary slot 7 beats secondary slot 0
    tbl.delete();
    put_entry(base, size, ea, 1'b1, 0, 20'h77700, 4'h7, 2'h1);
    put_entry(base, size, ea, 1'b0, 7, 20'h70007, 4'h3, 2'h2);
    run(ea, base, size, 1'b0);
    expect_res("R5", 1'b1, 20'h70007, 4'h3, 2'h2, 9);

    // R6: miss after both groups of decoys
    tbl.delete();
    fill_decoys(base, size, ea, 1'b0);
    fill_decoys(base, size, ea, 1'b1);
    run(ea, base, size, 1'b0);
    expect_res("R6", 1'b0, 20'h0, 4'h0, 2'h0, 16);

    // R2: larger table, hash bits above the 64 KiB mask select the group
    base = 32'h0100_0000; size = 32'h0004_0000; ea = 32'hF7FF_F000;
    tbl.delete();
    fill_decoys(base, size, ea, 1'b0);
    put_entry(base, size, ea, 1'b0, 6, 20'hC0FFE, 4'hA, 2'h3);
    run(ea, base, size, 1'b0);
    expect_res("R2", 1'b1, 20'hC0FFE, 4'hA, 2'h3, 8);

    // R8: request driven while busy is ignored
    base = 32'h0040_0000; size = 32'h0001_0000; ea = 32'h1234_5678;
    tbl.delete();
    put_entry(base, size, ea, 1'b0, 4, 20'h4A4A4, 4'hC, 2'h1);
    put_entry(base, size, ea ^ 32'h1000_0000, 1'b0, 0, 20'hEEEEE, 4'hE, 2'h3);
    run(ea, base, size, 1'b1);
    expect_res("R8", 1'b1, 20'h4A4A4, 4'hC, 2'h1, 6);

    // R7 R10: constrained random against the bench model
    for (int it = 0; it < 60; it++) begin
      int mode;
      int slot;
      size = 32'h0001_0000 << ($urandom % 3);
      base = $urandom & ~(size - 32'd1);
      ea   = $urandom;
      mode = $urandom % 3;
      slot = $urandom % 8;
      tbl.delete();
      fill_decoys(base, size, ea, 1'b0);
      fill_decoys(base, size, ea, 1'b1);
      if (mode == 1) put_entry(base, size, ea, 1'b0, slot, 20'($urandom), 4'($urandom), 2'($urandom));
      if (mode == 2) put_entry(base, size, ea, 1'b1, slot, 20'($urandom), 4'($urandom), 2'($urandom));
      ref_lookup(ea, base, size, e_hit, e_rpn, e_wimg, e_pp, e_reads);
      run(ea, base, size, 1'b0);
      expect_res("R7", e_hit, e_rpn, e_wimg, e_pp, e_reads);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule